// File: doc/BRIEF.md
# Virtual-Channel Power-Gating Controller

This block sits beside one router input port and decides which virtual channels are powered and how many storage entries each powered channel should keep awake. Channel VC0 has no storage: it is the cheapest way to carry traffic when the network is quiet. Channels VC1 and above are buffered. The controller runs a two-state policy. In the light-load state only VC0 and VC1 are on. In the heavy-load state VC0 is off, and higher channels are added as they congest and removed as they drain.

Each cycle the port reports, for every buffered channel, how many entries hold flits and how many entries are actually awake. The controller returns one enable bit per channel, a target count of awake entries per buffered channel, and the load-state bit. Within a powered channel it wakes one entry at a time whenever the spare awake room runs short. It puts one entry back to sleep only on a slow periodic tick. The minimum awake depth is the larger of the entry wake-up delay and the credit round-trip time.

Top module: `vc_power_ctrl`

## Requirements
- R1: After reset the load state is light (`hi_load_o`=0), `vc_en_o` has only bits 0 and 1 set, the VC1 target is the minimum depth P_ENT, and every other target is 0.
- R2: P_ENT is the larger of WAKE_DLY and CRT_LAT. With the defaults 2 and 3 the value is 3.
- R3: In the light state, a VC1 occupancy strictly above ENTER_THR turns on VC2 with target P_ENT and turns off VC0 on the same clock edge, and the state becomes heavy. An occupancy equal to ENTER_THR leaves the state light.
- R4: In the heavy state, a powered channel v (v ≥ 1) with occupancy ≥ CONG_THR whose channel v+1 is off turns v+1 on with target P_ENT. When several qualify, the lowest v is served. Congestion on the highest channel has no effect.
- R5: In the heavy state, if no channel is turned on, the highest powered channel v ≥ 2 with zero occupancy whose channel v−1 has occupancy below LIGHT_THR is turned off, and its target becomes 0.
- R6: In the heavy state, when every channel from VC2 up is off and VC1 occupancy is below LIGHT_THR, VC0 is turned on and the state returns to light. The state stays heavy while VC1 occupancy is at or above LIGHT_THR.
- R7: VC1 is always enabled. VC0 is disabled in the heavy state. Within the heavy state, at most one enable bit changes per clock edge.
- R8: For a powered buffered channel, idle = active − occupancy (0 if negative). If idle ≤ P_ENT − IDLE_Q, the target is below ENTRY_MAX and the active count equals the target, the target rises by one on that edge. This can repeat every cycle. No wake is issued while the active count lags the target.
- R9: If idle > P_ENT − IDLE_Q and the active count exceeds P_ENT, the target falls by one. This happens only on every GATE_T-th cycle, never by more than one.
- R10: On an edge where a channel is switched on or off, or the state changes, no entry wake is issued in any channel.
- R11: `occ_i`, `act_i` and `tgt_o` pack VC1 at bits [CW-1:0], VC2 at the next CW bits, and so on, with CW = clog2(ENTRY_MAX+1). A disabled channel's target is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_i | input | (NUM_VC-1)*CW | Occupied entries per buffered channel |
| act_i | input | (NUM_VC-1)*CW | Awake entries per buffered channel |
| vc_en_o | output | NUM_VC | Power enable per channel, bit 0 is VC0 |
| tgt_o | output | (NUM_VC-1)*CW | Awake-entry target per buffered channel |
| hi_load_o | output | 1 | Load state: 0 light, 1 heavy |

## Verification
A stepped occupancy table first lifts VC1 past the entry threshold, then congests VC2, and then congests the top channel. This separates a true channel turn-on from a congestion that can go nowhere. Dropping all occupancy to zero walks the channels back down one edge at a time. That shows whether gating runs highest-first and single-step, and whether the return to the light state waits until VC2 is off. Directed patterns tell apart the per-cycle wake rate and the periodic shrink rate, and a lagging active count shows that the block waits for a pending wake. An occupancy exactly at the entry threshold and a VC1 that is not quite light are used to find off-by-one errors in the state changes.

// File: rtl/vcpg_pkg.sv
package vcpg_pkg;

   typedef enum logic {
      LOAD_LOW  = 1'b0,
      LOAD_HIGH = 1'b1
   } load_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vcpg_tick.sv
module vcpg_tick #(
   parameter int GATE_T = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNTW = (GATE_T > 1) ? $clog2(GATE_T) : 1;
   localparam logic [CNTW-1:0] LAST = CNTW'(GATE_T - 1);

   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNTW'(1);
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/vcpg_entry_sizer.sv
module vcpg_entry_sizer #(
   parameter int CW        = 4,
   parameter int ENTRY_MAX = 8,
   parameter int P_ENT     = 3,
   parameter int IDLE_Q    = 1
) (
   input  logic [CW-1:0] occ_i,
   input  logic [CW-1:0] act_i,
   input  logic [CW-1:0] tgt_i,
   input  logic          gate_tick_i,
   output logic          wake_o,
   output logic          shrink_o
);
   localparam logic [CW-1:0] SLACK = CW'(P_ENT - IDLE_Q);
   localparam logic [CW-1:0] FULL  = CW'(ENTRY_MAX);
   localparam logic [CW-1:0] FLOOR = CW'(P_ENT);

   logic [CW-1:0] idle;

   always_comb begin
      idle     = (act_i > occ_i) ? (act_i - occ_i) : '0;
      wake_o   = (act_i == tgt_i) && (idle <= SLACK) && (tgt_i < FULL);
      shrink_o = gate_tick_i && (idle > SLACK) && (act_i > FLOOR);
   end
endmodule

// File: rtl/vcpg_channel_sel.sv
module vcpg_channel_sel
   import vcpg_pkg::*;
#(
   parameter int NUM_VC    = 4,
   parameter int CW        = 4,
   parameter int ENTER_THR = 5,
   parameter int CONG_THR  = 6,
   parameter int LIGHT_THR = 2
) (
   input  load_state_e                  state_i,
   input  logic [NUM_VC-1:0]            en_i,
   input  logic [(NUM_VC-1)*CW-1:0]     occ_i,
   output load_state_e                  state_nxt_o,
   output logic [NUM_VC-1:0]            en_nxt_o,
   output logic [NUM_VC-2:0]            on_mask_o,
   output logic                         evt_o
);
   localparam logic [CW-1:0] ENTER_C = CW'(ENTER_THR);
   localparam logic [CW-1:0] CONG_C  = CW'(CONG_THR);
   localparam logic [CW-1:0] LIGHT_C = CW'(LIGHT_THR);

   logic          found;
   logic [CW-1:0] occ_vc1;

   assign occ_vc1 = occ_i[CW-1:0];

   always_comb begin
      state_nxt_o = state_i;
      en_nxt_o    = en_i;
      on_mask_o   = '0;
      evt_o       = 1'b0;
      found       = 1'b0;
      if (state_i == LOAD_LOW) begin
         if (occ_vc1 > ENTER_C) begin
            en_nxt_o[0]  = 1'b0;
            en_nxt_o[2]  = 1'b1;
            on_mask_o[1] = 1'b1;
            state_nxt_o  = LOAD_HIGH;
            evt_o        = 1'b1;
         end
      end else if ((en_i[NUM_VC-1:2] == '0) && (occ_vc1 < LIGHT_C)) begin
         en_nxt_o[0] = 1'b1;
         state_nxt_o = LOAD_LOW;
         evt_o       = 1'b1;
      end else begin
         // channel growth first: lowest congested channel opens its neighbour
         for (int v = 1; v < NUM_VC - 1; v++) begin
            if (!found && en_i[v] && !en_i[v+1] &&
                (occ_i[(v-1)*CW +: CW] >= CONG_C)) begin
               found          = 1'b1;
               en_nxt_o[v+1]  = 1'b1;
               on_mask_o[v]   = 1'b1;
               evt_o          = 1'b1;
            end
         end
         // then shrink from the top: empty channel above a light one
         for (int v = NUM_VC - 1; v >= 2; v--) begin
            if (!found && en_i[v] && (occ_i[(v-1)*CW +: CW] == '0) &&
                (occ_i[(v-2)*CW +: CW] < LIGHT_C)) begin
               found       = 1'b1;
               en_nxt_o[v] = 1'b0;
               evt_o       = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vc_power_ctrl.sv
module vc_power_ctrl
   import vcpg_pkg::*;
#(
   parameter int NUM_VC    = 4,
   parameter int ENTRY_MAX = 8,
   parameter int WAKE_DLY  = 2,
   parameter int CRT_LAT   = 3,
   parameter int IDLE_Q    = 1,
   parameter int GATE_T    = 4,
   parameter int ENTER_THR = 5,
   parameter int CONG_THR  = 6,
   parameter int LIGHT_THR = 2,
   localparam int CW       = $clog2(ENTRY_MAX + 1),
   localparam int NB       = NUM_VC - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NB*CW-1:0]  occ_i,
   input  logic [NB*CW-1:0]  act_i,
   output logic [NUM_VC-1:0] vc_en_o,
   output logic [NB*CW-1:0]  tgt_o,
   output logic              hi_load_o
);
   localparam int P_ENT = max_int(WAKE_DLY, CRT_LAT);
   localparam logic [CW-1:0] P_C = CW'(P_ENT);
   localparam logic [NUM_VC-1:0] EN_RST = NUM_VC'(3);

   if (NUM_VC < 3) begin : g_bad_vc
      $error("vc_power_ctrl: NUM_VC must be at least 3");
   end
   if (P_ENT > ENTRY_MAX) begin : g_bad_depth
      $error("vc_power_ctrl: minimum depth exceeds ENTRY_MAX");
   end
   if (IDLE_Q > P_ENT) begin : g_bad_q
      $error("vc_power_ctrl: IDLE_Q must not exceed the minimum depth");
   end
   if (GATE_T < 2) begin : g_bad_t
      $error("vc_power_ctrl: GATE_T must be at least 2");
   end

   load_state_e       state_q, state_nxt;
   logic [NUM_VC-1:0] en_q, en_nxt;
   logic [NB-1:0]     on_mask;
   logic              evt;
   logic              gate_tick;

   vcpg_tick #(.GATE_T(GATE_T)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (gate_tick)
   );

   vcpg_channel_sel #(
      .NUM_VC    (NUM_VC),
      .CW        (CW),
      .ENTER_THR (ENTER_THR),
      .CONG_THR  (CONG_THR),
      .LIGHT_THR (LIGHT_THR)
   ) u_sel (
      .state_i     (state_q),
      .en_i        (en_q),
      .occ_i       (occ_i),
      .state_nxt_o (state_nxt),
      .en_nxt_o    (en_nxt),
      .on_mask_o   (on_mask),
      .evt_o       (evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LOAD_LOW;
         en_q    <= EN_RST;
      end else begin
         state_q <= state_nxt;
         en_q    <= en_nxt;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_buf
      logic [CW-1:0] tgt_q;
      logic          wake, shrink;

      vcpg_entry_sizer #(
         .CW        (CW),
         .ENTRY_MAX (ENTRY_MAX),
         .P_ENT     (P_ENT),
         .IDLE_Q    (IDLE_Q)
      ) u_sizer (
         .occ_i       (occ_i[b*CW +: CW]),
         .act_i       (act_i[b*CW +: CW]),
         .tgt_i       (tgt_q),
         .gate_tick_i (gate_tick),
         .wake_o      (wake),
         .shrink_o    (shrink)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        tgt_q <= (b == 0) ? P_C : '0;
         else if (!en_nxt[b+1])             tgt_q <= '0;
         else if (on_mask[b])               tgt_q <= P_C;
         else if (en_q[b+1] && wake && !evt) tgt_q <= tgt_q + CW'(1);
         else if (en_q[b+1] && shrink)      tgt_q <= tgt_q - CW'(1);
      end

      assign tgt_o[b*CW +: CW] = tgt_q;
   end

   assign vc_en_o   = en_q;
   assign hi_load_o = (state_q == LOAD_HIGH);
endmodule

// File: rtl/vc_power_ctrl_chk.sv
module vc_power_ctrl_chk #(
   parameter int NUM_VC = 4,
   parameter int CW     = 4,
   parameter int P_ENT  = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_VC-1:0]           vc_en_o,
   input logic [(NUM_VC-1)*CW-1:0]    tgt_o,
   input logic                        hi_load_o
);
   localparam logic [CW-1:0] P_C = CW'(P_ENT);

   // R7
   vc1_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vc_en_o[1]);

   // R7
   heavy_no_vc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_load_o |-> !vc_en_o[0]);

   // R1
   light_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_load_o |-> (vc_en_o[0] && vc_en_o[1] && (vc_en_o[NUM_VC-1:2] == '0)));

   // R7
   single_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_load_o && $past(hi_load_o)) |-> ($countones(vc_en_o ^ $past(vc_en_o)) <= 1));

   // R3
   enter_heavy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_load_o) |-> (vc_en_o[2] && (tgt_o[CW +: CW] == P_C)));

   for (genvar b = 0; b < NUM_VC - 1; b++) begin : g_chk
      // R11
      gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !vc_en_o[b+1] |-> (tgt_o[b*CW +: CW] == '0));

      // R9
      unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (vc_en_o[b+1] && $past(vc_en_o[b+1])) |->
            ((tgt_o[b*CW +: CW] == $past(tgt_o[b*CW +: CW])) ||
             (tgt_o[b*CW +: CW] == $past(tgt_o[b*CW +: CW]) + CW'(1)) ||
             (tgt_o[b*CW +: CW] == $past(tgt_o[b*CW +: CW]) - CW'(1))));
   end
endmodule

bind vc_power_ctrl vc_power_ctrl_chk #(
   .NUM_VC (NUM_VC),
   .CW     (CW),
   .P_ENT  (P_ENT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vc_en_o   (vc_en_o),
   .tgt_o     (tgt_o),
   .hi_load_o (hi_load_o)
);

// File: tb/vc_power_ctrl_test.sv
module vc_power_ctrl_test;
   localparam int NUM_VC = 4;
   localparam int CW     = 4;
   localparam int NB     = NUM_VC - 1;
   localparam int NROW   = 10;

   // row: occ[37:26] hold[25:18] en[17:14] hi[13] chk_tgt[12] tgt[11:0]
   localparam logic [37:0] TBL [NROW] = '{
      {12'h000, 8'd10, 4'b0011, 1'b0, 1'b1, 12'h003},
      {12'h006, 8'd1,  4'b0110, 1'b1, 1'b1, 12'h033},
      {12'h006, 8'd9,  4'b0110, 1'b1, 1'b1, 12'h038},
      {12'h066, 8'd1,  4'b1110, 1'b1, 1'b1, 12'h338},
      {12'h066, 8'd9,  4'b1110, 1'b1, 1'b1, 12'h388},
      {12'h666, 8'd10, 4'b1110, 1'b1, 1'b1, 12'h888},
      {12'h000, 8'd1,  4'b0110, 1'b1, 1'b0, 12'h000},
      {12'h000, 8'd1,  4'b0010, 1'b1, 1'b0, 12'h000},
      {12'h000, 8'd1,  4'b0011, 1'b0, 1'b0, 12'h000},
      {12'h000, 8'd30, 4'b0011, 1'b0, 1'b1, 12'h003}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NB*CW-1:0]  occ = '0;
   logic [NB*CW-1:0]  frz_val = '0;
   logic              frz = 1'b0;
   logic [NB*CW-1:0]  act_bus;
   logic [NUM_VC-1:0] vc_en;
   logic [NB*CW-1:0]  tgt;
   logic              hi_load;
   int                errs = 0;
   int                checks = 0;
   bit                done = 1'b0;

   always #4 clk = ~clk;

   assign act_bus = frz ? frz_val : tgt;

   vc_power_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .occ_i     (occ),
      .act_i     (act_bus),
      .vc_en_o   (vc_en),
      .tgt_o     (tgt),
      .hi_load_o (hi_load)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [31:0] actv, input logic [31:0] expv);
      checks++;
      if (actv !== expv) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actv, expv);
      end
   endtask

   function automatic string row_tag(input int i);
      case (i)
         0:       return "R1";
         1:       return "R10";
         2, 4:    return "R8";
         3, 5:    return "R4";
         6, 7:    return "R5";
         8:       return "R6";
         default: return "R9";
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] prev, cur;
      int drops;
      logic bad_step;

      // R1 / R2: reset values, minimum depth 3 = max(2,3)
      step(2);
      chk("R1", "enables in reset", 32'(vc_en), 32'b0011);
      chk("R1", "state in reset", 32'(hi_load), 32'd0);
      chk("R2", "VC1 target in reset", 32'(tgt), 32'h003);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         occ = TBL[i][37:26];
         step(int'(TBL[i][25:18]));
         chk(row_tag(i), "enables", 32'(vc_en), 32'(TBL[i][17:14]));
         chk(row_tag(i), "state", 32'(hi_load), 32'(TBL[i][13]));
         if (TBL[i][12]) chk(row_tag(i), "targets", 32'(tgt), 32'(TBL[i][11:0]));
      end
      // R11: gated VC2/VC3 fields read 0 in the last row above

      // R8: one wake per cycle; R3: occupancy equal to threshold stays light
      occ = 12'h005;
      step(2);
      chk("R8", "VC1 target after two wake cycles", 32'(tgt[CW-1:0]), 32'd5);
      step(10);
      chk("R3", "state at threshold occupancy", 32'(hi_load), 32'd0);

      // R9: shrink at most one per step, exactly 3 in 12 cycles at GATE_T=4
      occ = '0;
      prev = tgt[CW-1:0];
      drops = 0;
      bad_step = 1'b0;
      for (int c = 0; c < 12; c++) begin
         step(1);
         cur = tgt[CW-1:0];
         if (cur != prev) begin
            drops++;
            if (cur != prev - CW'(1)) bad_step = 1'b1;
         end
         prev = cur;
      end
      chk("R9", "shrinks in 12 cycles", 32'(drops), 32'd3);
      chk("R9", "shrink step size error", 32'(bad_step), 32'd0);
      step(20);
      chk("R9", "VC1 target settles at minimum", 32'(tgt[CW-1:0]), 32'd3);

      // R8: no further wake while the active count lags the target
      frz_val = tgt;
      frz = 1'b1;
      occ = 12'h005;
      step(3);
      chk("R8", "VC1 target with pending wake", 32'(tgt[CW-1:0]), 32'd4);
      frz = 1'b0;
      occ = '0;
      step(20);

      // R6: no return to light while VC1 is not light
      occ = 12'h006;
      step(1);
      chk("R3", "state after VC1 above threshold", 32'(hi_load), 32'd1);
      occ = 12'h003;
      step(5);
      chk("R6", "state with VC1 occupancy 3", 32'(hi_load), 32'd1);
      chk("R5", "VC2 kept while VC1 not light", 32'(vc_en), 32'b0110);
      occ = 12'h001;
      step(1);
      chk("R5", "VC2 gated once VC1 light", 32'(vc_en), 32'b0010);
      step(1);
      chk("R6", "return to light state", 32'(hi_load), 32'd0);
      chk("R7", "enables after return", 32'(vc_en), 32'b0011);

      // R1: reset in the middle of heavy operation
      occ = 12'h006;
      step(3);
      rst_n = 1'b0;
      #1;
      chk("R1", "enables after mid-run reset", 32'(vc_en), 32'b0011);
      chk("R1", "state after mid-run reset", 32'(hi_load), 32'd0);
      chk("R1", "targets after mid-run reset", 32'(tgt), 32'h003);
      occ = '0;
      step(1);
      rst_n = 1'b1;
      step(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule